// File: doc/BRIEF.md
# Three-Wire Byte Handshake Engine

This block is the device end of a byte-serial link to a host processor. Three active-low lines carry the handshake. The host drives a transfer-in-progress line and a transfer-acknowledge line. The device drives a transfer-request line. While the in-progress line is low, every change of the acknowledge/in-progress pair moves one byte. A direction bit from the host picks which way the byte goes. In output direction the host's shift-register byte is stored in a capture buffer. In input direction the next pending reply byte is placed on the shift-register output.

When the in-progress line is released, the transfer ends. A packet-received strobe reports the captured length, and the capture count starts again from zero. While the in-progress line stays high, the engine is in an idle sync phase. There the request line follows each change of the acknowledge line, and it is pulled low whenever reply bytes are still waiting. Each event asks for a shift-register interrupt. The interrupt is a one-cycle pulse that comes a fixed delay (20 µs worth of clock cycles) after the last request, and every new request restarts that delay. Local logic feeds reply bytes through a push port. Decoding the packet contents is left to the logic around the block.

Top module: `hslink_engine`

## Requirements
- R1: After reset the request output `treq_n` is 1 (inactive), `sr_irq` and `pkt_rx` are 0, and `cap_count` and `rep_pending` are 0.
- R2: While `tip_n` is 0, a byte moves only in a cycle where the pair {`tack_n`, `tip_n`} differs from its value in the previous cycle. A steady pair moves nothing.
- R3: With `dir_out` = 1, each qualifying change stores `sr_wr_data` at capture address `cap_count` and increments `cap_count`. Stored bytes are read back at `cap_rd_data` for the address on `cap_rd_addr`.
- R4: The capture buffer holds DEPTH (16) bytes. A qualifying change with `cap_count` = DEPTH stores nothing.
- R5: With `dir_out` = 0 and reply bytes pending, each qualifying change puts the next reply byte, oldest first, on `sr_rd_data`. When the last pending byte has been loaded, `treq_n` goes to 1.
- R6: When `tip_n` goes from 0 to 1, `pkt_rx` pulses for one cycle with `pkt_len` equal to the captured count if that count is nonzero, and `cap_count` returns to 0. With no byte captured there is no pulse, but an interrupt is still requested.
- R7: `sr_irq` is a one-cycle pulse. It appears exactly DELAY = TICKS_PER_US × DELAY_US clock edges after the edge that registers the requesting event. A later request restarts the delay.
- R8: When `tip_n` is 1 in both the current and the previous cycle, each change of `tack_n` makes `treq_n` equal to the new `tack_n` and requests an interrupt.
- R9: When `tip_n` is 1, the last cycle had `tip_n` = 1, `tack_n` did not change, and reply bytes are pending, `treq_n` is driven to 0.
- R10: `rep_push` appends `rep_byte` to the reply buffer and requests an interrupt. If nothing is pending, the push starts a new reply at index 0. A push while DEPTH bytes are pending is ignored.
- R11: A push in the same cycle as the load of the final pending byte keeps `treq_n` at 0, because one byte is still pending.
- R12: A new interrupt request in the cycle where the delay would expire wins: no pulse comes in that cycle, and the full delay starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tip_n | input | 1 | Host transfer-in-progress line, active low |
| tack_n | input | 1 | Host acknowledge line, active low |
| dir_out | input | 1 | 1: host sends bytes to the device; 0: device returns reply bytes |
| sr_wr_data | input | 8 | Shift-register byte written by the host |
| sr_rd_data | output | 8 | Shift-register byte loaded from the reply buffer |
| treq_n | output | 1 | Device request line, active low |
| rep_push | input | 1 | Append `rep_byte` to the reply buffer |
| rep_byte | input | 8 | Reply byte to append |
| rep_pending | output | $clog2(DEPTH+1) | Reply bytes not yet loaded |
| cap_count | output | $clog2(DEPTH+1) | Bytes captured in the current transfer |
| cap_rd_addr | input | $clog2(DEPTH) | Capture buffer read address |
| cap_rd_data | output | 8 | Capture buffer byte at `cap_rd_addr` |
| pkt_rx | output | 1 | One-cycle packet-received strobe |
| pkt_len | output | $clog2(DEPTH+1) | Length reported with the last strobe |
| sr_irq | output | 1 | One-cycle delayed shift-register interrupt |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a reply push and the acknowledge toggle that loads what was the final pending byte. The bench drives both in the same cycle. It then expects the request line to stay low and one byte to stay pending, and it expects the pushed byte to arrive on the next toggle. The second pair is a new interrupt request and the expiry of the running delay. The bench places a second acknowledge toggle exactly on the expiry edge. It then expects no pulse there, and a pulse one full delay after the second request.

// File: rtl/hslink_pkg.sv
package hslink_pkg;

    typedef logic [7:0] byte_t;

    // {tack_n, tip_n} as held between cycles; both lines idle high
    typedef logic [1:0] line_pair_t;
    localparam line_pair_t LINES_IDLE = 2'b11;

endpackage

// File: rtl/hslink_bytebuf.sv
module hslink_bytebuf
    import hslink_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    input  logic [AW-1:0] rd_addr,
    output byte_t         rd_data
);

    byte_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/hslink_irq_delay.sv
module hslink_irq_delay #(
    parameter int DELAY = 1000,
    localparam int CW = $clog2(DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic irq
);

    localparam logic [CW-1:0] LOAD = CW'(DELAY);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          irq_d, irq_q;

    always_comb begin
        cnt_d = cnt_q;
        irq_d = 1'b0;
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
            irq_d = (cnt_q == ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/hslink_engine.sv
module hslink_engine
    import hslink_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int TICKS_PER_US = 50,
    parameter int DELAY_US     = 20,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int DELAY = TICKS_PER_US * DELAY_US
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tip_n,
    input  logic          tack_n,
    input  logic          dir_out,
    input  logic [7:0]    sr_wr_data,
    output logic [7:0]    sr_rd_data,
    output logic          treq_n,
    input  logic          rep_push,
    input  logic [7:0]    rep_byte,
    output logic [CW-1:0] rep_pending,
    output logic [CW-1:0] cap_count,
    input  logic [AW-1:0] cap_rd_addr,
    output logic [7:0]    cap_rd_data,
    output logic          pkt_rx,
    output logic [CW-1:0] pkt_len,
    output logic          sr_irq
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        line_pair_t    last;
        logic          treq_n;
        byte_t         sr;
        logic [CW-1:0] cap_cnt;
        logic [CW-1:0] rep_size;
        logic [CW-1:0] rep_idx;
        logic [CW-1:0] pkt_len;
        logic          pkt_rx;
    } eng_st_t;

    eng_st_t       st_d, st_q;
    line_pair_t    lines;
    logic          moved, pend;
    logic          cap_we, rep_we, kick;
    logic [AW-1:0] rep_waddr;
    byte_t         rep_rdata;

    assign lines = {tack_n, tip_n};

    always_comb begin
        st_d        = st_q;
        st_d.pkt_rx = 1'b0;
        st_d.last   = lines;
        cap_we      = 1'b0;
        rep_we      = 1'b0;
        rep_waddr   = st_q.rep_size[AW-1:0];
        kick        = 1'b0;
        moved       = (lines != st_q.last);
        pend        = (st_q.rep_idx < st_q.rep_size);

        // reply buffer refill from local logic
        if (rep_push) begin
            if (!pend) begin
                rep_we        = 1'b1;
                rep_waddr     = '0;
                st_d.rep_size = ONE;
                st_d.rep_idx  = '0;
                kick          = 1'b1;
            end else if (st_q.rep_size < FULL) begin
                rep_we        = 1'b1;
                st_d.rep_size = st_q.rep_size + ONE;
                kick          = 1'b1;
            end
        end

        if (!tip_n) begin
            // transfer active
            if (dir_out) begin
                if (moved && (st_q.cap_cnt < FULL)) begin
                    cap_we       = 1'b1;
                    st_d.cap_cnt = st_q.cap_cnt + ONE;
                    kick         = 1'b1;
                end
            end else if (moved && pend) begin
                st_d.sr      = rep_rdata;
                st_d.rep_idx = st_q.rep_idx + ONE;
                if ((st_q.rep_idx + ONE) >= st_d.rep_size) begin
                    st_d.treq_n = 1'b1;
                end
                kick = 1'b1;
            end
        end else begin
            if (st_q.last[0] && (tack_n != st_q.last[1])) begin
                // idle sync phase: request mirrors acknowledge
                st_d.treq_n = tack_n;
                kick        = 1'b1;
            end else begin
                if (!st_q.last[0]) begin
                    // in-progress line just released
                    if (st_q.cap_cnt != '0) begin
                        st_d.pkt_rx  = 1'b1;
                        st_d.pkt_len = st_q.cap_cnt;
                        st_d.cap_cnt = '0;
                    end
                    kick = 1'b1;
                end
                if (pend) begin
                    st_d.treq_n = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.last   <= LINES_IDLE;
            st_q.treq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    hslink_bytebuf #(.DEPTH(DEPTH)) cap_buf_i (
        .clk     (clk),
        .wr_en   (cap_we),
        .wr_addr (st_q.cap_cnt[AW-1:0]),
        .wr_data (sr_wr_data),
        .rd_addr (cap_rd_addr),
        .rd_data (cap_rd_data)
    );

    hslink_bytebuf #(.DEPTH(DEPTH)) rep_buf_i (
        .clk     (clk),
        .wr_en   (rep_we),
        .wr_addr (rep_waddr),
        .wr_data (rep_byte),
        .rd_addr (st_q.rep_idx[AW-1:0]),
        .rd_data (rep_rdata)
    );

    hslink_irq_delay #(.DELAY(DELAY)) irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (kick),
        .irq   (sr_irq)
    );

    assign sr_rd_data  = st_q.sr;
    assign treq_n      = st_q.treq_n;
    assign rep_pending = st_q.rep_size - st_q.rep_idx;
    assign cap_count   = st_q.cap_cnt;
    assign pkt_rx      = st_q.pkt_rx;
    assign pkt_len     = st_q.pkt_len;

endmodule

// File: rtl/hslink_checks.sv
module hslink_checks #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tip_n,
    input logic          tack_n,
    input logic          dir_out,
    input logic          rep_push,
    input logic [7:0]    sr_rd_data,
    input logic [CW-1:0] cap_count,
    input logic [CW-1:0] rep_pending,
    input logic          pkt_rx,
    input logic [CW-1:0] pkt_len,
    input logic          sr_irq
);

    logic [1:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_count <= CW'(DEPTH)) && (rep_pending <= CW'(DEPTH)));

    assert_pkt_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_rx |-> (pkt_len != '0) && (cap_count == '0) && $past(tip_n));

    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_irq |=> !sr_irq);

    assert_steady_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen_q == 2'd3) && !$past(tip_n) && !$past(rep_push) &&
         ($past({tack_n, tip_n}) == $past({tack_n, tip_n}, 2)))
        |-> ($stable(cap_count) && $stable(sr_rd_data)));

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_rx |=> !pkt_rx);

endmodule

bind hslink_engine hslink_checks #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tip_n       (tip_n),
    .tack_n      (tack_n),
    .dir_out     (dir_out),
    .rep_push    (rep_push),
    .sr_rd_data  (sr_rd_data),
    .cap_count   (cap_count),
    .rep_pending (rep_pending),
    .pkt_rx      (pkt_rx),
    .pkt_len     (pkt_len),
    .sr_irq      (sr_irq)
);

// File: tb/hslink_engine_tb_top.sv
module hslink_engine_tb_top;

    localparam int DEPTH = 16;
    localparam int DLY   = 20;  // TICKS_PER_US = 1, scaled delay
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tip_n = 1'b1, tack_n = 1'b1, dir_out = 1'b0;
    logic [7:0]    sr_wr_data = '0, sr_rd_data, rep_byte = '0, cap_rd_data;
    logic          treq_n, rep_push = 1'b0, pkt_rx, sr_irq;
    logic [CW-1:0] rep_pending, cap_count, pkt_len;
    logic [AW-1:0] cap_rd_addr = '0;

    always #10 clk = ~clk;

    hslink_engine #(.DEPTH(DEPTH), .TICKS_PER_US(1), .DELAY_US(DLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .tack_n(tack_n),
        .dir_out(dir_out), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data),
        .treq_n(treq_n), .rep_push(rep_push), .rep_byte(rep_byte),
        .rep_pending(rep_pending), .cap_count(cap_count),
        .cap_rd_addr(cap_rd_addr), .cap_rd_data(cap_rd_data),
        .pkt_rx(pkt_rx), .pkt_len(pkt_len), .sr_irq(sr_irq)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] sent [32];
    logic [7:0] rep  [32];
    bit done = 1'b0;

    function automatic int clip(int n);
        return (n > DEPTH) ? DEPTH : n;
    endfunction

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drain();
        repeat (2 * DLY + 2) step();
    endtask

    task automatic irq_wait(output int n);
        n = 0;
        while (!sr_irq && n < 4 * DLY) begin
            step();
            n++;
        end
    endtask

    task automatic host_write(int n, bit hold);
        dir_out = 1'b1;
        for (int i = 0; i < n; i++) begin
            sent[i] = 8'($urandom);
            sr_wr_data = sent[i];
            if (i == 0) tip_n = 1'b0;
            else        tack_n = ~tack_n;
            step();
            chk("R3 cap_count", int'(cap_count), clip(i + 1));
            if (hold && i == 0) begin
                sr_wr_data = ~sent[0];
                repeat (3) step();
                chk("R2 steady lines keep count", int'(cap_count), 1);
            end
        end
        tip_n = 1'b1;
        step();
        chk("R6 pkt_rx", int'(pkt_rx), 1);
        chk("R6 pkt_len", int'(pkt_len), clip(n));
        chk("R6 cap_count cleared", int'(cap_count), 0);
        for (int i = 0; i < clip(n); i++) begin
            cap_rd_addr = AW'(i);
            #1;
            chk((n > DEPTH) ? "R4 kept byte" : "R3 stored byte",
                int'(cap_rd_data), int'(sent[i]));
        end
        step();
        chk("R6 pkt_rx single", int'(pkt_rx), 0);
    endtask

    task automatic push(int base, int n);
        for (int i = 0; i < n; i++) begin
            rep[base + i] = 8'($urandom);
            rep_byte = rep[base + i];
            rep_push = 1'b1;
            step();
        end
        rep_push = 1'b0;
        step();
    endtask

    // loads rep[from..to-1]; 'total' is the end of the pending reply
    task automatic host_read(int from, int to, int total);
        dir_out = 1'b0;
        for (int i = from; i < to; i++) begin
            if (i == from) tip_n = 1'b0;
            else           tack_n = ~tack_n;
            step();
            chk("R5 reply byte", int'(sr_rd_data), int'(rep[i]));
            chk("R5 treq after load", int'(treq_n), (i == total - 1) ? 1 : 0);
        end
        tip_n = 1'b1;
        step();
        chk("R6 no pkt on read", int'(pkt_rx), 0);
        step();
    endtask

    initial begin
        int n;
        void'($urandom(32'd4242));
        repeat (3) step();
        chk("R1 treq_n", int'(treq_n), 1);
        chk("R1 irq", int'(sr_irq), 0);
        chk("R1 pkt_rx", int'(pkt_rx), 0);
        chk("R1 cap_count", int'(cap_count), 0);
        chk("R1 rep_pending", int'(rep_pending), 0);
        rst_n = 1'b1;
        step();

        // sync phase and delay timing
        tack_n = 1'b0; step();
        chk("R8 treq follows tack low", int'(treq_n), 0);
        irq_wait(n);
        chk("R7 irq delay", n, DLY);
        step();
        chk("R7 irq one cycle", int'(sr_irq), 0);
        tack_n = 1'b1; step();
        chk("R8 treq follows tack high", int'(treq_n), 1);
        drain();

        // restart exactly at expiry
        tack_n = 1'b0; step();
        repeat (DLY - 1) step();
        chk("R12 no early pulse", int'(sr_irq), 0);
        tack_n = 1'b1; step();
        chk("R12 expiry suppressed", int'(sr_irq), 0);
        irq_wait(n);
        chk("R12 full delay after restart", n, DLY);
        drain();

        host_write(3, 1'b1);
        drain();
        host_write(20, 1'b0);
        drain();

        // empty transfer: no packet, still an interrupt
        dir_out = 1'b0;
        tip_n = 1'b0; step();
        drain();
        tip_n = 1'b1; step();
        chk("R6 no pkt when empty", int'(pkt_rx), 0);
        irq_wait(n);
        chk("R6 irq on empty end", n, DLY);
        drain();

        // full reply read
        push(0, 3);
        chk("R9 treq low when pending", int'(treq_n), 0);
        chk("R10 pending", int'(rep_pending), 3);
        host_read(0, 3, 3);
        chk("R5 all loaded", int'(rep_pending), 0);

        // partial read, then resume
        push(0, 3);
        host_read(0, 1, 3);
        chk("R9 treq low again", int'(treq_n), 0);
        chk("R9 pending left", int'(rep_pending), 2);
        host_read(1, 3, 3);

        // push on the final load
        push(0, 2);
        dir_out = 1'b0;
        tip_n = 1'b0; step();
        chk("R11 first byte", int'(sr_rd_data), int'(rep[0]));
        rep[2] = 8'($urandom);
        rep_byte = rep[2];
        rep_push = 1'b1;
        tack_n = ~tack_n; step();
        rep_push = 1'b0;
        chk("R11 byte", int'(sr_rd_data), int'(rep[1]));
        chk("R11 treq stays low", int'(treq_n), 0);
        chk("R11 pending", int'(rep_pending), 1);
        tack_n = ~tack_n; step();
        chk("R11 pushed byte", int'(sr_rd_data), int'(rep[2]));
        chk("R11 treq released", int'(treq_n), 1);
        tip_n = 1'b1; step();
        drain();

        // reply buffer full
        push(0, DEPTH + 2);
        chk("R10 full ignores push", int'(rep_pending), DEPTH);
        host_read(0, DEPTH, DEPTH);
        push(0, 1);
        chk("R10 restart at index 0", int'(rep_pending), 1);
        host_read(0, 1, 1);
        drain();

        // random rounds
        for (int r = 0; r < 8; r++) begin
            int wn, rn;
            wn = 1 + int'($urandom % 20);
            rn = 1 + int'($urandom % DEPTH);
            host_write(wn, 1'b0);
            push(0, rn);
            chk("R9 random pending", int'(treq_n), 0);
            host_read(0, rn, rn);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule